// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two data ports, A and B, and carries data either way through a storage stage for each direction. The width is split into independent sections. Each section has a chip select, a capture gate and a drive enable for the A-to-B path, and another three for the B-to-A path. Each direction has its own storage register, so a value can be parked in one direction while the other direction is in use. When the controls of every section are tied together, the block behaves as a single full-width transceiver.

Capture is modelled against the system clock. At each rising edge where a direction's chip select and capture gate are both low, that direction's register loads its source port. The gate that actually governs capture is therefore the OR of the two active-low signals. A direction drives its destination port only while power is good and both its chip select and drive enable are low. Otherwise that port is released.

Tri-state pins are split at the boundary into data-out, per-bit output-enable and data-in signals. Each input bit also has a flag that says whether something outside is driving it. An undriven input bit is replaced by a keeper value, which is the last value seen while the bit was driven. If both directions of one section drive at the same moment, a per-section flag reports the conflict. The storage registers have no reset, so their contents mean nothing until the first capture.

Top module: `lbt_xcvr`

## Requirements
- R1: At a rising clock edge where a direction's chip select and capture gate are both low, that direction's register loads its source data. The new value appears on the data output from that edge onward.
- R2: While the capture gate is high, the register keeps its value across clock edges, whatever the source data does.
- R3: While the chip select is high, the register keeps its value even when the capture gate is low.
- R4: `b_oe` bits of a section are all 1 exactly when `pwr_ok` is 1 and that section's A-to-B chip select and drive enable are both 0. Otherwise they are all 0. While enabled, `b_out` shows the A-to-B register.
- R5: The B-to-A direction follows R1 to R4 with its own controls, its own register, `a_out` and `a_oe`. Capturing in one direction leaves the other direction's stored value unchanged.
- R6: While `pwr_ok` is 0, every bit of `a_oe` and `b_oe` is 0, whatever the controls are.
- R7: For an input bit whose drive flag is 0, the value used for capture is the last value of that bit sampled with its drive flag at 1, or 0 if no such value has been sampled since reset.
- R8: `contention[s]` is 1 exactly when both directions of section s are driving their ports at the same time.
- R9: The controls of section s affect only data bits s*SECW to s*SECW+SECW-1, so section 0 owns the low bits.
- R10: With the same controls applied to every section, the whole width moves as one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Active-low reset; clears the input keepers only |
| pwr_ok | input | 1 | Supply good; when low, all outputs are released |
| ab_cs_n | input | NSEC | A-to-B chip select per section, active low |
| ab_le_n | input | NSEC | A-to-B capture gate per section, active low |
| ab_oe_n | input | NSEC | A-to-B drive enable per section, active low |
| ba_cs_n | input | NSEC | B-to-A chip select per section, active low |
| ba_le_n | input | NSEC | B-to-A capture gate per section, active low |
| ba_oe_n | input | NSEC | B-to-A drive enable per section, active low |
| a_in | input | NSEC*SECW | Level seen on the A pins |
| a_drv | input | NSEC*SECW | Per-bit flag: an external driver is on the A pin |
| b_in | input | NSEC*SECW | Level seen on the B pins |
| b_drv | input | NSEC*SECW | Per-bit flag: an external driver is on the B pin |
| a_out | output | NSEC*SECW | Value driven toward A (B-to-A register) |
| a_oe | output | NSEC*SECW | Per-bit drive enable for A |
| b_out | output | NSEC*SECW | Value driven toward B (A-to-B register) |
| b_oe | output | NSEC*SECW | Per-bit drive enable for B |
| contention | output | NSEC | Both directions of a section driving at once |

## Verification
Several properties are checked on every cycle: the hold of a stored value while either capture control is high, the load from the source after an open edge, the release of all enables when power is not good or the chip select is high, keeper stability on undriven bits, and agreement between the contention flag and the two sides' enables. The bench's scenarios are needed for the rest. They show section independence, that one direction's register is untouched by captures in the other, the keeper value after mixed driven and undriven bits, and full-width behaviour with tied controls, all compared against a reference model.

// File: rtl/lbt_pkg.sv
`timescale 1ns/1ps
package lbt_pkg;
  localparam int unsigned LBT_NSEC = 2;
  localparam int unsigned LBT_SECW = 18;

  typedef struct packed {
    logic cs_n;
    logic le_n;
    logic oe_n;
  } lbt_ctl_t;
endpackage

// File: rtl/lbt_keeper.sv
`timescale 1ns/1ps
module lbt_keeper #(
  parameter int unsigned W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] drv,
  output logic [W-1:0] eff
);
  logic [W-1:0] hold_q;

  assign eff = (drv & pin) | (~drv & hold_q);

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= eff;
  end

  AST_KEEP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    ((~drv & ~$past(drv) & (eff ^ $past(eff))) == '0)); // R7
endmodule

// File: rtl/lbt_path.sv
`timescale 1ns/1ps
module lbt_path #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_ok,
  input  lbt_pkg::lbt_ctl_t ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] doe,
  output logic         drive
);
  logic [W-1:0] store_q;
  logic         open_gate;

  assign open_gate = ~(ctl.cs_n | ctl.le_n);
  assign drive     = pwr_ok & ~ctl.cs_n & ~ctl.oe_n;
  assign doe       = {W{drive}};
  assign dout      = store_q;

  always_ff @(posedge clk) begin
    if (open_gate) store_q <= din;
  end

  AST_LOAD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.cs_n && !ctl.le_n) |=> (dout == $past(din))); // R1
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.le_n |=> $stable(dout)); // R2
  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.cs_n |=> $stable(dout)); // R3
  AST_CS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.cs_n |-> (doe == '0)); // R4
  AST_PWR_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> (doe == '0)); // R6
endmodule

// File: rtl/lbt_section.sv
`timescale 1ns/1ps
module lbt_section #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_ok,
  input  lbt_pkg::lbt_ctl_t ab_ctl,
  input  lbt_pkg::lbt_ctl_t ba_ctl,
  input  logic [W-1:0] a_eff,
  input  logic [W-1:0] b_eff,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  output logic         fight
);
  logic ab_drive;
  logic ba_drive;

  lbt_path #(.W(W)) u_ab (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ctl(ab_ctl),
    .din(a_eff), .dout(b_out), .doe(b_oe), .drive(ab_drive)
  );

  lbt_path #(.W(W)) u_ba (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ctl(ba_ctl),
    .din(b_eff), .dout(a_out), .doe(a_oe), .drive(ba_drive)
  );

  assign fight = ab_drive & ba_drive;

  AST_FIGHT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    fight == ((|a_oe) && (|b_oe))); // R8
endmodule

// File: rtl/lbt_xcvr.sv
`timescale 1ns/1ps
module lbt_xcvr #(
  parameter int unsigned NSEC = lbt_pkg::LBT_NSEC,
  parameter int unsigned SECW = lbt_pkg::LBT_SECW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_ok,
  input  logic [NSEC-1:0]      ab_cs_n,
  input  logic [NSEC-1:0]      ab_le_n,
  input  logic [NSEC-1:0]      ab_oe_n,
  input  logic [NSEC-1:0]      ba_cs_n,
  input  logic [NSEC-1:0]      ba_le_n,
  input  logic [NSEC-1:0]      ba_oe_n,
  input  logic [NSEC*SECW-1:0] a_in,
  input  logic [NSEC*SECW-1:0] a_drv,
  input  logic [NSEC*SECW-1:0] b_in,
  input  logic [NSEC*SECW-1:0] b_drv,
  output logic [NSEC*SECW-1:0] a_out,
  output logic [NSEC*SECW-1:0] a_oe,
  output logic [NSEC*SECW-1:0] b_out,
  output logic [NSEC*SECW-1:0] b_oe,
  output logic [NSEC-1:0]      contention
);
  localparam int unsigned W = NSEC * SECW;

  logic [W-1:0] a_eff;
  logic [W-1:0] b_eff;

  lbt_keeper #(.W(W)) u_keep_a (
    .clk(clk), .rst_n(rst_n), .pin(a_in), .drv(a_drv), .eff(a_eff)
  );

  lbt_keeper #(.W(W)) u_keep_b (
    .clk(clk), .rst_n(rst_n), .pin(b_in), .drv(b_drv), .eff(b_eff)
  );

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    lbt_pkg::lbt_ctl_t ab_ctl;
    lbt_pkg::lbt_ctl_t ba_ctl;

    assign ab_ctl = '{cs_n: ab_cs_n[s], le_n: ab_le_n[s], oe_n: ab_oe_n[s]};
    assign ba_ctl = '{cs_n: ba_cs_n[s], le_n: ba_le_n[s], oe_n: ba_oe_n[s]};

    lbt_section #(.W(SECW)) u_sec (
      .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
      .ab_ctl(ab_ctl), .ba_ctl(ba_ctl),
      .a_eff(a_eff[s*SECW +: SECW]), .b_eff(b_eff[s*SECW +: SECW]),
      .a_out(a_out[s*SECW +: SECW]), .a_oe(a_oe[s*SECW +: SECW]),
      .b_out(b_out[s*SECW +: SECW]), .b_oe(b_oe[s*SECW +: SECW]),
      .fight(contention[s])
    );
  end

  AST_NO_PWR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> (a_oe == '0 && b_oe == '0 && contention == '0)); // R6
endmodule

// File: tb/sim_lbt_xcvr.sv
`timescale 1ns/1ps
module sim_lbt_xcvr;
  localparam int NSEC = 2;
  localparam int SECW = 18;
  localparam int W    = NSEC * SECW;
  localparam int NVEC = 8;

  // {ab cs,le,oe, ba cs,le,oe} then A data then B data; controls tied across sections
  localparam logic [6+2*W-1:0] VEC [NVEC] = '{
    {6'b000111, 36'h123456789, 36'h000000000},
    {6'b010111, 36'hFEDCBA987, 36'h000000000},
    {6'b110111, 36'h0F0F0F0F0, 36'h000000000},
    {6'b010111, 36'h555555555, 36'h000000000},
    {6'b111000, 36'h333333333, 36'hABCDE0123},
    {6'b111010, 36'h444444444, 36'h111111111},
    {6'b001011, 36'h9ABCDEF01, 36'h222222222},
    {6'b011111, 36'h666666666, 36'h777777777}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0;
  logic [NSEC-1:0] ab_cs_n = '1, ab_le_n = '1, ab_oe_n = '1;
  logic [NSEC-1:0] ba_cs_n = '1, ba_le_n = '1, ba_oe_n = '1;
  logic [W-1:0] a_in = '0, a_drv = '1, b_in = '0, b_drv = '1;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic [NSEC-1:0] contention;

  int errors = 0;
  int checks = 0;

  logic [W-1:0] r_ab = '0, r_ba = '0, k_a = '0, k_b = '0;
  logic [NSEC-1:0] def_ab = '0, def_ba = '0;

  always #5 clk = ~clk;

  lbt_xcvr #(.NSEC(NSEC), .SECW(SECW)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
    .ab_cs_n(ab_cs_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_cs_n(ba_cs_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .a_in(a_in), .a_drv(a_drv), .b_in(b_in), .b_drv(b_drv),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
    .contention(contention)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(
    input logic [NSEC-1:0] abc, input logic [NSEC-1:0] abl, input logic [NSEC-1:0] abo,
    input logic [NSEC-1:0] bac, input logic [NSEC-1:0] bal, input logic [NSEC-1:0] bao,
    input logic [W-1:0] ai, input logic [W-1:0] ad,
    input logic [W-1:0] bi, input logic [W-1:0] bd,
    input logic pw, input string tag);
    logic [W-1:0] ea, eb, xb, xa, mb, ma;
    logic [NSEC-1:0] dab, dba;
    @(negedge clk);
    ab_cs_n = abc; ab_le_n = abl; ab_oe_n = abo;
    ba_cs_n = bac; ba_le_n = bal; ba_oe_n = bao;
    a_in = ai; a_drv = ad; b_in = bi; b_drv = bd; pwr_ok = pw;
    ea = (ad & ai) | (~ad & k_a);
    eb = (bd & bi) | (~bd & k_b);
    xa = '0; xb = '0; ma = '0; mb = '0;
    for (int s = 0; s < NSEC; s++) begin
      if (!abc[s] && !abl[s]) begin r_ab[s*SECW +: SECW] = ea[s*SECW +: SECW]; def_ab[s] = 1'b1; end
      if (!bac[s] && !bal[s]) begin r_ba[s*SECW +: SECW] = eb[s*SECW +: SECW]; def_ba[s] = 1'b1; end
      dab[s] = pw & !abc[s] & !abo[s];
      dba[s] = pw & !bac[s] & !bao[s];
      xb[s*SECW +: SECW] = {SECW{dab[s]}};
      xa[s*SECW +: SECW] = {SECW{dba[s]}};
      mb[s*SECW +: SECW] = {SECW{dab[s] & def_ab[s]}};
      ma[s*SECW +: SECW] = {SECW{dba[s] & def_ba[s]}};
    end
    if (rst_n) begin k_a = ea; k_b = eb; end
    else begin k_a = '0; k_b = '0; end
    @(posedge clk); #1;
    chk({tag, " b_oe"}, b_oe, xb);
    chk({tag, " a_oe"}, a_oe, xa);
    chk({tag, " b_out"}, b_out & mb, r_ab & mb);
    chk({tag, " a_out"}, a_out & ma, r_ba & ma);
    chk({tag, " contention"}, {{(W-NSEC){1'b0}}, contention}, {{(W-NSEC){1'b0}}, dab & dba});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R6: power not good, all enables low, in reset: nothing drives
    apply('0, '0, '0, '0, '0, '0, 36'hAAAAAAAAA, '1, 36'h555555555, '1, 1'b0, "R6 reset no power");
    rst_n = 1'b1;
    // R4: power good, chip selects high: released
    apply('1, '1, '0, '1, '1, '0, 36'h0, '1, 36'h0, '1, 1'b1, "R4 cs high");
    // R10 plus R1..R5 over the vector table, controls tied across sections
    for (int i = 0; i < NVEC; i++) begin
      logic [5:0] c;
      c = VEC[i][6+2*W-1 -: 6];
      apply({NSEC{c[5]}}, {NSEC{c[4]}}, {NSEC{c[3]}}, {NSEC{c[2]}}, {NSEC{c[1]}}, {NSEC{c[0]}},
            VEC[i][2*W-1 -: W], '1, VEC[i][W-1:0], '1, 1'b1, $sformatf("R10 vec%0d", i));
    end
    // R9: section 0 loads and drives, section 1 holds and floats
    apply(2'b10, 2'b10, 2'b10, '1, '1, '1, 36'hCAFEBABE1, '1, '0, '1, 1'b1, "R9 split");
    apply(2'b00, 2'b11, 2'b00, '1, '1, '1, 36'h0, '1, '0, '1, 1'b1, "R9 split readback");
    // R7: drive once, then float some bits, capture keeper values
    apply('0, '0, '0, '1, '1, '1, 36'h13579BDF0, '1, '0, '1, 1'b1, "R7 drive");
    apply('0, '0, '0, '1, '1, '1, 36'hFFFFFFFFF, 36'h00000FFFF, '0, '1, 1'b1, "R7 partial float");
    apply('0, '0, '0, '1, '1, '1, 36'h000000000, '0, '0, '1, 1'b1, "R7 all float");
    // R5: B-to-A capture leaves A-to-B store alone
    apply('0, '1, '0, '0, '0, '1, 36'h0, '1, 36'h2468ACE02, '1, 1'b1, "R5 ba load");
    apply('0, '1, '0, '0, '1, '0, 36'h0, '1, 36'h0, '1, 1'b1, "R5 ba readback");
    // R8: both directions of section 1 driving
    apply(2'b00, '1, 2'b00, 2'b01, '1, 2'b01, '0, '1, '0, '1, 1'b1, "R8 contention");
    // R6: power drops with all enables on, then store survives
    apply('0, '1, '0, '0, '1, '0, '0, '1, '0, '1, 1'b0, "R6 power drop");
    apply('0, '1, '0, '0, '1, '0, '0, '1, '0, '1, 1'b1, "R6 power back");
    // R2 R3: cs high with le low does not load
    apply('1, '0, '0, '1, '0, '0, 36'hDEADBEEF0, '1, 36'hBEEFDEAD0, '1, 1'b1, "R3 cs freezes");
    apply('0, '1, '0, '1, '1, '1, 36'h0, '1, 36'h0, '1, 1'b1, "R2 R3 readback");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule